// File: doc/BRIEF.md
# Programmable Queue Threshold Flags

This block produces the almost-full and almost-empty indications for a dual-clock queue. It watches the queue's write pointer, which lives in the write-clock domain, and its read pointer, which lives in the read-clock domain. It compares the queue's fill level against two programmable thresholds. The queue storage is outside the block. Only the two pointers and the programming controls enter it.

Both thresholds are loaded from a small built-in preset table during a master reset. A 3-bit selector picks one entry, and that entry is used for both thresholds. After reset, software can overwrite the thresholds in two ways:
- a parallel port, 8 or 9 bits per transfer;
- a serial bit stream.

A partial reset restarts the flag logic and the load sequences but keeps the thresholds. Each flag can be set to one of two modes:
- registered on its own port clock, with the opposite pointer brought across through a Gray-coded synchroniser;
- combinational on the raw pointers, so it follows either clock without waiting for an edge of its own.

Top module: `qtf_flags`

## Requirements
- R1: While `mrst_n` is low, each write-clock edge loads both thresholds with (2 << `preset_sel`) - 1, giving 1, 3, 7 … 255 for selector values 0 … 7. This replaces any programmed value.
- R2: Occupancy is (`wr_ptr` - `rd_ptr`) modulo 2^(ADDR_W+1). `almost_empty` is 1 exactly when occupancy is less than or equal to the empty threshold.
- R3: Free space is 2^ADDR_W minus occupancy. `almost_full` is 1 exactly when free space is less than or equal to the full threshold.
- R4: Parallel transfers happen on each write-clock edge with `pload_en` high and both resets released. Transfers fill the empty threshold first, then the full threshold, lowest chunk first.
  - With `pload_w9`=1, a chunk is `pload_data[8:0]`.
  - With `pload_w9`=0, a chunk is `pload_data[7:0]`. For ADDR_W=9 this takes two transfers per threshold: bits 7:0 first, then bit 8 taken from `pload_data[0]`.
- R5: After the last chunk of the full threshold, the next parallel transfer goes back to the lowest chunk of the empty threshold.
- R6: Serial loading shifts one bit from `ser_bit` on each write-clock edge while `ser_en_n` is low and `pload_en` is low.
  - The first ADDR_W bits fill the empty threshold, LSB first.
  - The next ADDR_W bits fill the full threshold, LSB first.
  - The stream then starts again at the empty threshold.
- R7: While `prst_n` is low and `mrst_n` is high:
  - both thresholds keep their values;
  - parallel and serial loads are ignored;
  - both load sequences restart at the empty threshold's first chunk or bit.
- R8: In registered mode, any reset edge forces `almost_empty` to 1 and `almost_full` to 0.
- R9: In registered mode, each flag changes only on an edge of its own clock.
  - A change of its own-domain pointer shows after 1 edge.
  - A change of the opposite pointer shows after 4 edges: a source register, two synchroniser stages and the flag register. This assumes equal clocks.
- R10: With `af_async`/`ae_async` set to 1, the flag follows the raw pointers and thresholds with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| mrst_n | input | 1 | Master reset, active low, synchronous |
| prst_n | input | 1 | Partial reset, active low, synchronous |
| preset_sel | input | 3 | Preset table index, used during master reset |
| pload_w9 | input | 1 | Parallel chunk width: 1 = 9 bits, 0 = 8 bits |
| af_async | input | 1 | Almost-full mode: 1 = combinational, 0 = registered |
| ae_async | input | 1 | Almost-empty mode: 1 = combinational, 0 = registered |
| wr_ptr | input | ADDR_W+1 | Queue write pointer (write domain) |
| rd_ptr | input | ADDR_W+1 | Queue read pointer (read domain) |
| pload_en | input | 1 | Parallel transfer strobe |
| pload_data | input | 9 | Parallel threshold chunk |
| ser_en_n | input | 1 | Serial shift enable, active low |
| ser_bit | input | 1 | Serial threshold bit |
| almost_full | output | 1 | Almost-full flag |
| almost_empty | output | 1 | Almost-empty flag |

## Verification
Timing differs by mode:
- Registered flags reflect their own pointer one edge after it moves and the opposite pointer four edges after it moves.
- A threshold write shows on a registered flag one edge after the loading edge.
- Combinational flags change within the same clock low phase.

The bench drives every input on the falling edge. The threshold sweeps wait five edges before sampling on a falling edge, which covers the longest registered path. The latency checks sample at one edge and again at three and four edges, so an extra or missing pipeline stage is caught. The combinational checks sample two nanoseconds after the pointers move, well before any rising edge.

// File: rtl/qtf_pkg.sv
`timescale 1ns/1ps
package qtf_pkg;
  // fill level of a queue whose pointers carry one wrap bit
  function automatic int occ_of(int wr, int rd, int ptr_mod);
    return (wr - rd + ptr_mod) % ptr_mod;
  endfunction

  // built-in threshold table: 1, 3, 7, ... 255
  function automatic int preset_ofs(logic [2:0] sel);
    return (2 << sel) - 1;
  endfunction

  function automatic logic low_hit(int occ, int ofs);
    return occ <= ofs;
  endfunction

  function automatic logic high_hit(int occ, int depth, int ofs);
    return (depth - occ) <= ofs;
  endfunction
endpackage

// File: rtl/qtf_offsets.sv
`timescale 1ns/1ps
module qtf_offsets #(
  parameter int OFS_W = 9
) (
  input  logic             clk,
  input  logic             mrst_n,
  input  logic             prst_n,
  input  logic [2:0]       preset_sel,
  input  logic             pload_en,
  input  logic             pload_w9,
  input  logic [8:0]       pload_data,
  input  logic             ser_en_n,
  input  logic             ser_bit,
  output logic [OFS_W-1:0] ae_ofs_o,
  output logic [OFS_W-1:0] af_ofs_o
);
  import qtf_pkg::*;

  localparam int NX8    = (OFS_W + 7) / 8;
  localparam int NX9    = (OFS_W + 8) / 9;
  localparam int PL_N   = 2 * NX8;
  localparam int IDX_W  = (PL_N > 1) ? $clog2(PL_N) : 1;
  localparam int SR_N   = 2 * OFS_W;
  localparam int SIDX_W = $clog2(SR_N);

  logic [IDX_W-1:0]  pl_idx;
  logic [SIDX_W-1:0] sr_idx;
  logic              run, pl_fire, sr_fire, pl_to_af, pl_last, sr_to_af, sr_last;
  int                nx, wdt, chunk, spos;
  logic [OFS_W-1:0]  pl_next;

  function automatic logic [OFS_W-1:0] place_chunk(logic [OFS_W-1:0] cur,
      logic [8:0] d, int ck, int w);
    logic [OFS_W-1:0] r;
    r = cur;
    for (int b = 0; b < OFS_W; b++)
      if (b >= ck * w && b < ck * w + w) r[b] = d[b - ck * w];
    return r;
  endfunction

  assign run     = mrst_n & prst_n;
  assign pl_fire = run & pload_en;
  assign sr_fire = run & ~ser_en_n & ~pload_en;

  always_comb begin
    nx       = pload_w9 ? NX9 : NX8;
    wdt      = pload_w9 ? 9 : 8;
    pl_to_af = int'(pl_idx) >= nx;
    chunk    = pl_to_af ? int'(pl_idx) - nx : int'(pl_idx);
    pl_last  = int'(pl_idx) == 2 * nx - 1;
    pl_next  = place_chunk(pl_to_af ? af_ofs_o : ae_ofs_o, pload_data, chunk, wdt);
    sr_to_af = int'(sr_idx) >= OFS_W;
    spos     = sr_to_af ? int'(sr_idx) - OFS_W : int'(sr_idx);
    sr_last  = int'(sr_idx) == SR_N - 1;
  end

  always_ff @(posedge clk) begin
    if (!mrst_n) begin
      ae_ofs_o <= OFS_W'(preset_ofs(preset_sel));
      af_ofs_o <= OFS_W'(preset_ofs(preset_sel));
      pl_idx   <= '0;
      sr_idx   <= '0;
    end else if (!prst_n) begin
      pl_idx <= '0;
      sr_idx <= '0;
    end else if (pl_fire) begin
      if (pl_to_af) af_ofs_o <= pl_next;
      else          ae_ofs_o <= pl_next;
      pl_idx <= pl_last ? '0 : pl_idx + 1'b1;
    end else if (sr_fire) begin
      if (sr_to_af) af_ofs_o[spos] <= ser_bit;
      else          ae_ofs_o[spos] <= ser_bit;
      sr_idx <= sr_last ? '0 : sr_idx + 1'b1;
    end
  end
endmodule

// File: rtl/qtf_ptr_sync.sv
`timescale 1ns/1ps
module qtf_ptr_sync #(
  parameter int W = 10
) (
  input  logic         src_clk,
  input  logic         src_rst_n,
  input  logic         dst_clk,
  input  logic         dst_rst_n,
  input  logic [W-1:0] bin_i,
  output logic [W-1:0] bin_o
);
  logic [W-1:0] src_g, f1_g, f2_g;

  always_ff @(posedge src_clk) begin
    if (!src_rst_n) src_g <= '0;
    else            src_g <= bin_i ^ (bin_i >> 1);
  end

  always_ff @(posedge dst_clk) begin
    if (!dst_rst_n) begin
      f1_g <= '0;
      f2_g <= '0;
    end else begin
      f1_g <= src_g;
      f2_g <= f1_g;
    end
  end

  always_comb begin
    bin_o[W-1] = f2_g[W-1];
    for (int i = W - 2; i >= 0; i--) bin_o[i] = bin_o[i+1] ^ f2_g[i];
  end
endmodule

// File: rtl/qtf_flag_stage.sv
`timescale 1ns/1ps
module qtf_flag_stage #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_mode,
  input  logic eval_sync,
  input  logic eval_async,
  output logic flag_o
);
  logic flag_q;

  always_ff @(posedge clk) begin
    if (!rst_n) flag_q <= RST_VAL;
    else        flag_q <= eval_sync;
  end

  assign flag_o = async_mode ? eval_async : flag_q;
endmodule

// File: rtl/qtf_flags.sv
`timescale 1ns/1ps
module qtf_flags #(
  parameter int ADDR_W = 9
) (
  input  logic            wclk,
  input  logic            rclk,
  input  logic            mrst_n,
  input  logic            prst_n,
  input  logic [2:0]      preset_sel,
  input  logic            pload_w9,
  input  logic            af_async,
  input  logic            ae_async,
  input  logic [ADDR_W:0] wr_ptr,
  input  logic [ADDR_W:0] rd_ptr,
  input  logic            pload_en,
  input  logic [8:0]      pload_data,
  input  logic            ser_en_n,
  input  logic            ser_bit,
  output logic            almost_full,
  output logic            almost_empty
);
  import qtf_pkg::*;

  localparam int OFS_W   = ADDR_W;
  localparam int PTR_W   = ADDR_W + 1;
  localparam int DEPTH   = 1 << ADDR_W;
  localparam int PTR_MOD = 2 * DEPTH;

  logic             rst_n;
  logic [OFS_W-1:0] ae_ofs, af_ofs;
  logic [PTR_W-1:0] rd_in_w, wr_in_r;
  logic             af_eval_sync, af_eval_async, ae_eval_sync, ae_eval_async;

  assign rst_n = mrst_n & prst_n;

  qtf_offsets #(.OFS_W(OFS_W)) u_ofs (
    .clk(wclk), .mrst_n(mrst_n), .prst_n(prst_n), .preset_sel(preset_sel),
    .pload_en(pload_en), .pload_w9(pload_w9), .pload_data(pload_data),
    .ser_en_n(ser_en_n), .ser_bit(ser_bit),
    .ae_ofs_o(ae_ofs), .af_ofs_o(af_ofs)
  );

  qtf_ptr_sync #(.W(PTR_W)) u_rd2w (
    .src_clk(rclk), .src_rst_n(rst_n), .dst_clk(wclk), .dst_rst_n(rst_n),
    .bin_i(rd_ptr), .bin_o(rd_in_w)
  );

  qtf_ptr_sync #(.W(PTR_W)) u_wr2r (
    .src_clk(wclk), .src_rst_n(rst_n), .dst_clk(rclk), .dst_rst_n(rst_n),
    .bin_i(wr_ptr), .bin_o(wr_in_r)
  );

  assign af_eval_sync  = high_hit(occ_of(int'(wr_ptr), int'(rd_in_w), PTR_MOD), DEPTH, int'(af_ofs));
  assign af_eval_async = high_hit(occ_of(int'(wr_ptr), int'(rd_ptr), PTR_MOD), DEPTH, int'(af_ofs));
  assign ae_eval_sync  = low_hit(occ_of(int'(wr_in_r), int'(rd_ptr), PTR_MOD), int'(ae_ofs));
  assign ae_eval_async = low_hit(occ_of(int'(wr_ptr), int'(rd_ptr), PTR_MOD), int'(ae_ofs));

  qtf_flag_stage #(.RST_VAL(1'b0)) u_af (
    .clk(wclk), .rst_n(rst_n), .async_mode(af_async),
    .eval_sync(af_eval_sync), .eval_async(af_eval_async), .flag_o(almost_full)
  );

  qtf_flag_stage #(.RST_VAL(1'b1)) u_ae (
    .clk(rclk), .rst_n(rst_n), .async_mode(ae_async),
    .eval_sync(ae_eval_sync), .eval_async(ae_eval_async), .flag_o(almost_empty)
  );
endmodule

// File: rtl/qtf_flags_chk.sv
`timescale 1ns/1ps
module qtf_flags_chk #(
  parameter int ADDR_W = 9
) (
  input logic            wclk,
  input logic            rclk,
  input logic            mrst_n,
  input logic            prst_n,
  input logic [2:0]      preset_sel,
  input logic            af_async,
  input logic            ae_async,
  input logic [ADDR_W:0] wr_ptr,
  input logic [ADDR_W:0] rd_ptr,
  input logic [ADDR_W-1:0] ae_ofs,
  input logic [ADDR_W-1:0] af_ofs,
  input logic            almost_full,
  input logic            almost_empty
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int PMASK = 2 * DEPTH - 1;

  // R1: master reset loads both thresholds from the selected table entry
  a_r1_preset_load: assert property (@(posedge wclk)
    !mrst_n |=> (int'(ae_ofs) == ((1 << (int'($past(preset_sel)) + 1)) - 1)) &&
                (int'(af_ofs) == ((1 << (int'($past(preset_sel)) + 1)) - 1)));

  // R7: thresholds untouched across a partial reset
  a_r7_prst_keeps_offsets: assert property (@(posedge wclk) disable iff (!mrst_n)
    !prst_n |=> $stable(ae_ofs) && $stable(af_ofs));

  // R8: reset values of the registered flags
  a_r8_ae_reset_value: assert property (@(posedge rclk)
    (!mrst_n || !prst_n) |=> (ae_async || almost_empty));
  a_r8_af_reset_value: assert property (@(posedge wclk)
    (!mrst_n || !prst_n) |=> (af_async || !almost_full));

  // R10: combinational flags follow raw pointers
  a_r10_af_follows_ptrs: assert property (@(posedge wclk) disable iff (!mrst_n)
    af_async |-> almost_full == ((DEPTH - (int'(wr_ptr - rd_ptr) & PMASK)) <= int'(af_ofs)));
  a_r10_ae_follows_ptrs: assert property (@(posedge rclk) disable iff (!mrst_n)
    ae_async |-> almost_empty == ((int'(wr_ptr - rd_ptr) & PMASK) <= int'(ae_ofs)));
endmodule

bind qtf_flags qtf_flags_chk #(.ADDR_W(ADDR_W)) u_chk (
  .wclk(wclk), .rclk(rclk), .mrst_n(mrst_n), .prst_n(prst_n),
  .preset_sel(preset_sel), .af_async(af_async), .ae_async(ae_async),
  .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .ae_ofs(ae_ofs), .af_ofs(af_ofs),
  .almost_full(almost_full), .almost_empty(almost_empty)
);

// File: tb/tb_qtf_flags.sv
`timescale 1ns/1ps
module tb_qtf_flags;
  localparam int AW    = 9;
  localparam int DEP   = 512;
  localparam int PMOD  = 1024;
  localparam int BASE  = 700;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        mrst_n, prst_n, pload_w9, af_async, ae_async, pload_en, ser_en_n, ser_bit;
  logic [2:0]  preset_sel;
  logic [AW:0] wr_ptr, rd_ptr;
  logic [8:0]  pload_data;
  logic        almost_full, almost_empty;

  qtf_flags #(.ADDR_W(AW)) dut (
    .wclk(clk), .rclk(clk), .mrst_n(mrst_n), .prst_n(prst_n),
    .preset_sel(preset_sel), .pload_w9(pload_w9), .af_async(af_async),
    .ae_async(ae_async), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr),
    .pload_en(pload_en), .pload_data(pload_data), .ser_en_n(ser_en_n),
    .ser_bit(ser_bit), .almost_full(almost_full), .almost_empty(almost_empty)
  );

  int total = 0, bad = 0;
  int m_ae, m_af;
  bit done = 0;

  task automatic chk(string req, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0b exp=%0b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic put(int occ);
    rd_ptr = (AW+1)'(BASE);
    wr_ptr = (AW+1)'((BASE + occ) % PMOD);
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  task automatic point(string req, int occ);
    put(occ);
    settle();
    chk({req, " ae"}, almost_empty, occ <= m_ae);
    chk({req, " af"}, almost_full, (DEP - occ) <= m_af);
  endtask

  // R2 and R3 thresholds probed at and next to both edges
  task automatic probe(string req);
    point({req, "/R2"}, m_ae);
    point({req, "/R2"}, m_ae + 1);
    if (m_ae > 0) point({req, "/R2"}, m_ae - 1);
    point({req, "/R3"}, DEP - m_af);
    point({req, "/R3"}, DEP - m_af - 1);
  endtask

  task automatic mreset(int sel);
    mrst_n = 0; preset_sel = 3'(sel);
    repeat (2) @(negedge clk);
    mrst_n = 1;
    m_ae = (2 ** (sel + 1)) - 1;
    m_af = m_ae;
  endtask

  task automatic pload(int d);
    pload_en = 1; pload_data = 9'(d);
    @(negedge clk);
    pload_en = 0;
  endtask

  task automatic sbits(int v, int n);
    for (int i = 0; i < n; i++) begin
      ser_en_n = 0; ser_bit = v[i];
      @(negedge clk);
    end
    ser_en_n = 1;
  endtask

  initial begin
    mrst_n = 0; prst_n = 1; preset_sel = 0; pload_w9 = 1; af_async = 0; ae_async = 0;
    wr_ptr = 0; rd_ptr = 0; pload_en = 0; pload_data = 0; ser_en_n = 1; ser_bit = 0;
    @(negedge clk);
    chk("R8 reset ae", almost_empty, 1'b1);
    chk("R8 reset af", almost_full, 1'b0);

    for (int s = 0; s < 8; s++) begin
      mreset(s);
      probe("R1");
    end

    pload_w9 = 1;
    pload(300); pload(5);
    m_ae = 300; m_af = 5;
    probe("R4");

    pload_w9 = 0;
    pload(8'h81); pload(0); pload(8'h90); pload(1);
    m_ae = 129; m_af = 400;
    probe("R5");

    sbits(200, AW); sbits(37, AW);
    m_ae = 200; m_af = 37;
    probe("R6");
    sbits(17, AW); sbits(450, AW);
    m_ae = 17; m_af = 450;
    probe("R6");

    pload_w9 = 1;
    pload(99);
    sbits(31, 5);
    m_ae = 127;
    put(300);
    prst_n = 0; pload_en = 1; pload_data = 0; ser_en_n = 0;
    @(negedge clk);
    chk("R8 prst ae", almost_empty, 1'b1);
    chk("R8 prst af", almost_full, 1'b0);
    @(negedge clk);
    prst_n = 1; pload_en = 0; ser_en_n = 1;
    probe("R7");
    pload(60); pload(70);
    m_ae = 60; m_af = 70;
    probe("R7");
    sbits(88, AW); sbits(250, AW);
    m_ae = 88; m_af = 250;
    probe("R7");

    mreset(5);
    probe("R1");

    mreset(2);
    put(8); settle();
    rd_ptr = rd_ptr + 1'b1;
    #1 chk("R9 ae before edge", almost_empty, 1'b0);
    @(negedge clk);
    chk("R9 ae own ptr 1 edge", almost_empty, 1'b1);
    wr_ptr = wr_ptr + 1'b1;
    repeat (3) @(negedge clk);
    chk("R9 ae far ptr 3 edges", almost_empty, 1'b1);
    @(negedge clk);
    chk("R9 ae far ptr 4 edges", almost_empty, 1'b0);
    put(DEP - 8); settle();
    wr_ptr = wr_ptr + 1'b1;
    #1 chk("R9 af before edge", almost_full, 1'b0);
    @(negedge clk);
    chk("R9 af own ptr 1 edge", almost_full, 1'b1);
    rd_ptr = rd_ptr + 1'b1;
    repeat (3) @(negedge clk);
    chk("R9 af far ptr 3 edges", almost_full, 1'b1);
    @(negedge clk);
    chk("R9 af far ptr 4 edges", almost_full, 1'b0);

    af_async = 1; ae_async = 1;
    for (int o = 5; o <= 9; o++) begin
      put(o);
      #2 chk("R10 ae comb", almost_empty, o <= m_ae);
      @(negedge clk);
    end
    for (int f = 5; f <= 9; f++) begin
      put(DEP - f);
      #2 chk("R10 af comb", almost_full, f <= m_af);
      @(negedge clk);
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #4000000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule